// File: doc/BRIEF.md
# UART Register Front End

This block sits between a 32-bit register bus and the serial parts of a simple UART. A receiver hands it bytes one at a time over a valid/ready pair. The block queues them in an eight-entry receive FIFO. Software drains the FIFO by reading the receive data register. A write to the transmit data register hands the low byte of the written word to a transmit sink, as a one-cycle strobe.

The block also holds transmit-control, receive-control, divisor and interrupt-enable words as plain storage for the serial logic. It has a read-only pending register. It drives one level-sensitive interrupt line, which is high while receive interrupts are enabled and the FIFO holds data. An access to an offset that no register occupies returns zero and pulses an error flag.

The register offsets are: 0x00 transmit data, 0x04 receive data, 0x08 transmit control, 0x0C receive control, 0x10 interrupt enable, 0x14 pending, 0x18 divisor. Bit 1 of the enable and pending registers is the receive interrupt. Bit 0 is a transmit enable bit that is stored but has no effect.

Top module: `uart_reg_front`

## Requirements
- R1: After reset the FIFO is empty and rx_ready_o is 1. irq_o, tx_valid_o and err_o are 0. The control registers read 0, interrupt enable reads 0 and the divisor reads 16.
- R2: The transmit-control (0x08), receive-control (0x0C) and divisor (0x18) registers store and return all 32 written bits. The interrupt-enable register (0x10) stores bits [1:0] and reads zero in bits [31:2].
- R3: A byte offered on rx_valid_i is accepted while fewer than 8 bytes are held, and rx_ready_o shows this. A byte offered while 8 are held is dropped, and the FIFO contents are unchanged.
- R4: A read of 0x04 with data held returns the oldest byte in bits [7:0], with zeros above it, and removes that byte. Bytes come out in arrival order.
- R5: A read of 0x04 with the FIFO empty returns 0x8000_0000 (bit 31 set) and removes nothing.
- R6: A write to 0x00 raises tx_valid_o for exactly the next cycle, with tx_data_o equal to bits [7:0] of the written word. A read of 0x00 returns zero.
- R7: The pending register (0x14) reads bit 1 = 1 while the FIFO is non-empty, whatever the enable bits hold. All other bits read 0, and writes to it are ignored.
- R8: irq_o is 1 exactly when enable bit 1 is set and the FIFO is non-empty. Enable bit 0 has no effect on irq_o.
- R9: An access to an offset above 0x18, or to one that is not a multiple of 4, returns zero and raises err_o for one cycle. It changes no register.
- R10: A receive-data read and a receiver push may fall in the same cycle. The read returns the oldest byte held before that edge. The push is accepted if and only if the FIFO was not full before that edge.
- R11: rdata_o and err_o are registered and valid in the cycle after the request. rdata_o reads zero after a write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| err_o | output | 1 | One-cycle pulse after an unmapped access |
| rx_valid_i | input | 1 | Receiver offers a byte |
| rx_data_i | input | 8 | Offered byte |
| rx_ready_o | output | 1 | FIFO can accept a byte |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Receive interrupt level |

## Verification
A software read of the receive data register and a receiver push can land on the same clock edge. That edge both shifts the FIFO forward and writes a new tail slot. The bench drives both inputs in one cycle at every fill level from empty to full. It checks that the returned byte is the oldest one held before that edge. It then drains the FIFO and compares the remaining bytes and their order with a queue model, in which the new byte is appended only if the FIFO was not full before the edge.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int BUS_W      = 32;
  localparam int BYTE_W     = 8;
  localparam int NUM_REGS   = 7;
  // register index; byte offset = index * 4
  localparam int REG_TXD    = 0;
  localparam int REG_RXD    = 1;
  localparam int REG_TXC    = 2;
  localparam int REG_RXC    = 3;
  localparam int REG_IE     = 4;
  localparam int REG_IP     = 5;
  localparam int REG_DIV    = 6;
  localparam int IE_W       = 2;
  localparam int IE_TX_BIT  = 0;
  localparam int IE_RX_BIT  = 1;
  localparam int RX_EMPTY_BIT = 31;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int DW     = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [CW-1:0] count_q;
  logic          push_ok, pop_ok;
  logic [CW-1:0] wr_idx;
  logic [DW-1:0] slots [DEPTH];

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  // acceptance judged on the count before the edge
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign wr_idx  = pop_ok ? count_q - CW'(1) : count_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DW-1:0] slot_q;
    logic [DW-1:0] nxt;
    if (g == DEPTH - 1) begin : g_last
      assign nxt = slot_q;
    end else begin : g_mid
      assign nxt = slots[g+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             slot_q <= '0;
      else if (push_ok && wr_idx == CW'(g))    slot_q <= push_data_i;
      else if (pop_ok)                         slot_q <= nxt;
    end
    assign slots[g] = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_q + CW'(push_ok) - CW'(pop_ok);
  end

  assign head_o  = slots[0];
  assign count_o = count_q;
endmodule

// File: rtl/uart_addr_dec.sv
module uart_addr_dec
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] hit_o,
  output logic                unmapped_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit_o[g] = (addr_i == ADDR_W'(g * 4));
  end
  assign unmapped_o = ~|hit_o;
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_reg_pkg::*;
#(
  parameter int          ADDR_W  = 5,
  parameter int          DEPTH   = 8,
  parameter logic [31:0] DIV_RST = 32'd16,
  localparam int         CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] hit;
  logic                unmapped;
  logic                rd_req, wr_req, pop;
  logic [BYTE_W-1:0]   fifo_head;
  logic [CW-1:0]       fifo_cnt;
  logic                fifo_full, fifo_empty;
  logic [BUS_W-1:0]    txctrl_q, rxctrl_q, div_q, rd_val, rdata_q;
  logic [IE_W-1:0]     ie_q;
  logic                err_q, tx_valid_q;
  logic [BYTE_W-1:0]   tx_data_q;

  uart_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i     (addr_i),
    .hit_o      (hit),
    .unmapped_o (unmapped)
  );

  assign rd_req = req_i && !we_i;
  assign wr_req = req_i && we_i;
  assign pop    = rd_req && hit[REG_RXD];

  uart_rx_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rx_valid_i),
    .push_data_i (rx_data_i),
    .pop_i       (pop),
    .head_o      (fifo_head),
    .count_o     (fifo_cnt),
    .full_o      (fifo_full),
    .empty_o     (fifo_empty)
  );

  assign rx_ready_o = !fifo_full;
  assign irq_o      = ie_q[IE_RX_BIT] && !fifo_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txctrl_q <= '0;
      rxctrl_q <= '0;
      div_q    <= DIV_RST;
      ie_q     <= '0;
    end else if (wr_req) begin
      if (hit[REG_TXC]) txctrl_q <= wdata_i;
      if (hit[REG_RXC]) rxctrl_q <= wdata_i;
      if (hit[REG_DIV]) div_q    <= wdata_i;
      if (hit[REG_IE])  ie_q     <= wdata_i[IE_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit[REG_RXD]) begin
      if (fifo_empty) rd_val[RX_EMPTY_BIT] = 1'b1;
      else            rd_val[BYTE_W-1:0]   = fifo_head;
    end
    if (hit[REG_TXC]) rd_val = txctrl_q;
    if (hit[REG_RXC]) rd_val = rxctrl_q;
    if (hit[REG_DIV]) rd_val = div_q;
    if (hit[REG_IE])  rd_val[IE_W-1:0] = ie_q;
    if (hit[REG_IP])  rd_val[IE_RX_BIT] = !fifo_empty;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      err_q      <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      err_q      <= req_i && unmapped;
      tx_valid_q <= wr_req && hit[REG_TXD];
      if (wr_req && hit[REG_TXD]) tx_data_q <= wdata_i[BYTE_W-1:0];
      if (req_i) rdata_q <= we_i ? '0 : rd_val;
    end
  end

  assign rdata_o    = rdata_q;
  assign err_o      = err_q;
  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;
endmodule

// File: rtl/uart_reg_front_chk.sv
module uart_reg_front_chk #(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              err_o,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              tx_valid_o,
  input logic [7:0]        tx_data_o,
  input logic              irq_o,
  input logic [CW-1:0]     fifo_cnt,
  input logic [1:0]        ie_q
);
  logic rx_rd;
  assign rx_rd = req_i && !we_i && (addr_i == ADDR_W'(4));

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  a_r3_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == CW'(DEPTH)) |-> !rx_ready_o);

  a_r3_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == CW'(DEPTH) && !rx_rd) |=> (fifo_cnt == CW'(DEPTH)));

  a_r4_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd && fifo_cnt != '0 && !rx_valid_i) |=> (fifo_cnt == $past(fifo_cnt) - CW'(1)));

  a_r5_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd && fifo_cnt == '0) |=> (rdata_o == 32'h8000_0000));

  a_r6_tx_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == '0) |=> (tx_valid_o && tx_data_o == $past(wdata_i[7:0])));

  a_r8_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (ie_q[1] && fifo_cnt != '0));

  a_r9_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[1:0] != 2'b00) |=> (err_o && rdata_o == '0));
endmodule

bind uart_reg_front uart_reg_front_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .err_o      (err_o),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .irq_o      (irq_o),
  .fifo_cnt   (fifo_cnt),
  .ie_q       (ie_q)
);

// File: tb/sim_uart_reg_front.sv
module sim_uart_reg_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err, rx_ready, tx_valid, irq;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [7:0]  tx_data;

  always #4 clk = ~clk;

  uart_reg_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_ready_o(rx_ready), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .irq_o(irq)
  );

  int errs = 0, checks = 0;
  logic [7:0]  q[$];
  logic [31:0] m_txc = '0, m_rxc = '0, m_div = 32'd16;
  logic [1:0]  m_ie = '0;
  logic [31:0] r_d;
  logic        r_e, t_v;
  logic [7:0]  t_d;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_rd(input int a);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a[4:0];
    @(negedge clk); req = 1'b0; r_d = rdata; r_e = err;
  endtask

  task automatic bus_wr(input int a, input logic [31:0] w);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a[4:0]; wdata = w;
    @(negedge clk); req = 1'b0; we = 1'b0; r_d = rdata; r_e = err; t_v = tx_valid; t_d = tx_data;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    if (q.size() < 8) q.push_back(b);
  endtask

  function automatic logic [31:0] exp_rx();
    if (q.size() == 0) return 32'h8000_0000;
    return {24'h0, q.pop_front()};
  endfunction

  function automatic logic [31:0] exp_reg(input int a);
    case (a)
      8:  return m_txc;
      12: return m_rxc;
      16: return {30'h0, m_ie};
      20: return (q.size() != 0) ? 32'h2 : 32'h0;
      24: return m_div;
      default: return 32'h0;
    endcase
  endfunction

  task automatic drain(input string tag);
    while (q.size() != 0) begin
      bus_rd(4);
      check(tag, r_d, exp_rx());
    end
    bus_rd(4);
    check("R5 empty read after drain", r_d, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    check("R1 err", {31'h0, err}, 32'h0);
    for (int a = 0; a <= 24; a += 4) begin
      if (a == 4) continue;
      bus_rd(a);
      check($sformatf("R1 reset value @%0h", a), r_d, exp_reg(a));
    end
    bus_rd(4);
    check("R5 empty read at reset", r_d, 32'h8000_0000);
    bus_rd(0);
    check("R6 tx data reads zero", r_d, 32'h0);

    // R2 storage
    bus_wr(8, 32'hA5A5_0F0F);  m_txc = 32'hA5A5_0F0F;
    check("R11 rdata zero after write", r_d, 32'h0);
    bus_wr(12, 32'h1234_8001); m_rxc = 32'h1234_8001;
    bus_wr(24, 32'hDEAD_BEEF); m_div = 32'hDEAD_BEEF;
    bus_wr(16, 32'hFFFF_FFFF); m_ie = 2'b11;
    for (int a = 8; a <= 24; a += 4) begin
      bus_rd(a);
      check($sformatf("R2 readback @%0h", a), r_d, exp_reg(a));
      check("R11 no err on mapped read", {31'h0, r_e}, 32'h0);
    end

    // R6 transmit strobe
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      w = 32'h0102_0300 * (i + 1) + 32'h5A * i;
      bus_wr(0, w);
      check("R6 tx_valid pulse", {31'h0, t_v}, 32'h1);
      check("R6 tx_data", {24'h0, t_d}, {24'h0, w[7:0]});
      @(negedge clk);
      check("R6 tx_valid one cycle", {31'h0, tx_valid}, 32'h0);
    end

    // R3 R4 R7 R8 fill and drain under every enable pattern
    for (int ie = 0; ie < 4; ie++) begin
      bus_wr(16, ie); m_ie = ie[1:0];
      for (int n = 0; n < 10; n++) begin
        push(8'((n * 37 + ie * 11) & 8'hFF));
        check("R3 rx_ready vs fill", {31'h0, rx_ready}, {31'h0, q.size() < 8});
        check("R8 irq level", {31'h0, irq}, {31'h0, m_ie[1] && q.size() != 0});
        bus_rd(20);
        check("R7 pending bit", r_d, exp_reg(20));
      end
      drain("R4 fifo order after overflow (R3 drop)");
      check("R8 irq low when empty", {31'h0, irq}, 32'h0);
    end

    // R10 simultaneous read and push at every fill level
    bus_wr(16, 32'h2); m_ie = 2'b10;
    for (int k = 0; k <= 8; k++) begin
      int pre;
      logic [31:0] e;
      for (int j = 0; j < k; j++) push(8'(8'hC0 + j));
      pre = q.size();
      @(negedge clk); req = 1'b1; we = 1'b0; addr = 5'd4; rx_valid = 1'b1; rx_data = 8'(8'h30 + k);
      @(negedge clk); req = 1'b0; rx_valid = 1'b0; r_d = rdata;
      e = exp_rx();
      if (pre < 8) q.push_back(8'(8'h30 + k));
      check($sformatf("R10 read during push k=%0d", k), r_d, e);
      check("R10 irq after combo", {31'h0, irq}, {31'h0, q.size() != 0});
      drain("R10 contents after combo");
    end

    // R9 offset sweep, reads
    for (int a = 0; a < 32; a++) begin
      bit mapped;
      logic [31:0] e;
      mapped = (a % 4 == 0) && (a <= 24);
      bus_rd(a);
      e = !mapped ? 32'h0 : (a == 4 ? exp_rx() : exp_reg(a));
      check($sformatf("R9 err @%0h", a), {31'h0, r_e}, {31'h0, !mapped});
      check($sformatf("R9 rdata @%0h", a), r_d, e);
    end
    // R9 unmapped writes change nothing; R7 pending ignores writes
    push(8'h77);
    for (int a = 0; a < 32; a++) begin
      if ((a % 4 == 0) && (a <= 24)) continue;
      bus_wr(a, 32'hFFFF_FFFF);
      check($sformatf("R9 write err @%0h", a), {31'h0, r_e}, 32'h1);
      check("R9 no tx on unmapped", {31'h0, t_v}, 32'h0);
    end
    bus_wr(20, 32'hFFFF_FFFF);
    check("R7 write to pending no err", {31'h0, r_e}, 32'h0);
    for (int a = 8; a <= 24; a += 4) begin
      bus_rd(a);
      check($sformatf("R9 state kept @%0h", a), r_d, exp_reg(a));
    end
    drain("R9 fifo kept");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule